// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns one externally supplied address into the array address for each of the four data cycles of a burst. On a load cycle with the device selected it captures the external address and the read/write control. On each advance cycle it steps an internal two-bit beat counter and forms the next array address from the captured start address, leaving the external address inputs out of the picture.

A static mode pin picks the beat order. In linear order the two low address bits count upward from the start value and wrap within the aligned group of four words. In interleaved order they are the start bits XORed with the beat number. A load cycle with the device deselected ends any burst in progress. Advances then produce no valid access until the next selected load. A suspend input freezes every register for as long as it is held.

The outputs feed the memory pipeline directly: the array address, a valid flag and the write flag that came with the load.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held low, and after it until the first selected load, `arr_valid` is 0.
- R2: A cycle with `suspend`=0, `adv`=0 and `sel`=1 makes `arr_valid`=1, `arr_addr`=`ext_addr` and `arr_wr`=`cmd_wr` from the next cycle on.
- R3: On an advance cycle (`suspend`=0, `adv`=1) neither `ext_addr` nor `sel` has any effect, and the upper `ADDR_W-2` bits of `arr_addr` keep the value they had at the load.
- R4: With `ilv_mode`=0 each advance of a valid burst sets `arr_addr[1:0]` to its previous value plus 1, modulo 4 (start 2 gives 2,3,0,1).
- R5: With `ilv_mode`=1 the beat-k address has `arr_addr[1:0]` equal to the start bits XOR k, for k = 0,1,2,3 (start 1 gives 1,0,3,2).
- R6: An advance after the fourth beat wraps to the first beat's address of the same four-word group; the burst does not stop.
- R7: A cycle with `suspend`=0, `adv`=0 and `sel`=0 makes `arr_valid`=0 from the next cycle; later advances keep `arr_valid`=0 until a selected load.
- R8: While `suspend`=1 the outputs and the internal state hold their values whatever the other inputs do.
- R9: `arr_wr` keeps the value captured at the load for every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| suspend | input | 1 | 1 freezes all registers for this cycle |
| adv | input | 1 | 1 = advance the burst, 0 = load/deselect |
| sel | input | 1 | Device selected, sampled on load cycles only |
| ext_addr | input | ADDR_W | External start address |
| cmd_wr | input | 1 | Write (1) or read (0) control, captured on load |
| ilv_mode | input | 1 | Beat order: 1 interleaved, 0 linear; static while a burst runs |
| arr_addr | output | ADDR_W | Array address for the current beat |
| arr_valid | output | 1 | A burst access is in progress this cycle |
| arr_wr | output | 1 | Write flag of the current burst |

## Verification
Bursts are started at a low address of 2 in linear order and 1 in interleaved order, so that a wrong carry, a missing XOR or an early stop each give a different low-bit sequence. The external address and select are changed on every advance cycle, which separates a design that really ignores them from one that samples them. Suspend cycles carry a selected load with a different address to show the freeze. Deselect is followed by advances, and then a back-to-back load starts a new burst over a running one, to tell the end of a burst from a restart.

// File: rtl/bseq_pkg.sv
// Package: shared types of the burst address sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package bseq_pkg;

    // Operation that the control decodes for one clock cycle.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,   // suspended: no register moves
        OP_LOAD  = 3'd1,   // selected load: capture address and control
        OP_END   = 3'd2,   // deselected load: end the burst
        OP_STEP  = 3'd3,   // advance of a running burst
        OP_IDLE  = 3'd4    // advance with no burst running
    } op_e;

endpackage

// File: rtl/bseq_ctrl.sv
// Module: bseq_ctrl
// Decodes the cycle's operation and keeps the burst state: the running
// flag, the beat counter and the captured write flag.
// Assumes: synchronous active-low reset; the beat counter wraps freely.
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend,
    input  logic              adv,
    input  logic              sel,
    input  logic              cmd_wr,
    output op_e               op,
    output logic              active,
    output logic [BEAT_W-1:0] beat,
    output logic              wr
);

    // Decode the operation from the sampled controls and the burst state.
    always_comb begin
        if (suspend)
            op = OP_HOLD;
        else if (!adv)
            op = sel ? OP_LOAD : OP_END;
        else
            op = active ? OP_STEP : OP_IDLE;
    end

    // Update the running flag, beat count and write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
            wr     <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    active <= 1'b1;
                    beat   <= '0;
                    wr     <= cmd_wr;
                end
                OP_END: begin
                    active <= 1'b0;
                    beat   <= '0;
                end
                OP_STEP: beat <= beat + 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bseq_addr_reg.sv
// Module: bseq_addr_reg
// Holds the start address of the burst, split into the fixed upper part
// and the low beat-select bits.
// Assumes: ADDR_W > BEAT_W; written only on a selected load.
module bseq_addr_reg #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2,
    localparam int UP_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [UP_W-1:0]   upper,
    output logic [BEAT_W-1:0] start_lo
);

    // Capture the external address on a selected load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper    <= '0;
            start_lo <= '0;
        end else if (load) begin
            upper    <= ext_addr[ADDR_W-1:BEAT_W];
            start_lo <= ext_addr[BEAT_W-1:0];
        end
    end

endmodule

// File: rtl/bseq_order.sv
// Module: bseq_order
// Forms the low address bits of the current beat from the start bits and
// the beat number, in linear (add, wrapping) or interleaved (XOR) order.
// Assumes: the mode input is static while a burst runs.
module bseq_order #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv_mode,
    output logic [BEAT_W-1:0] lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] xor_lo;

    // Interleaved order: one XOR per address bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xor_lo[i] = start_lo[i] ^ beat[i];
    end

    // Linear order: add the beat and drop the carry out of the group.
    always_comb lin_lo = start_lo + beat;

    // Select the order requested by the mode input.
    always_comb lo = ilv_mode ? xor_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Produces the array address, valid and write flag for each beat of a
// four-word burst from one loaded start address.
// Assumes: synchronous active-low reset; ilv_mode does not change while
// a burst is running; sel is sampled on load cycles only.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend,
    input  logic              adv,
    input  logic              sel,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              cmd_wr,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_valid,
    output logic              arr_wr
);

    localparam int UP_W = ADDR_W - BEAT_W;

    op_e               op;
    logic              active;
    logic [BEAT_W-1:0] beat;
    logic              wr;
    logic [UP_W-1:0]   upper;
    logic [BEAT_W-1:0] start_lo;
    logic [BEAT_W-1:0] lo;
    logic              load;

    // Burst state and cycle decode.
    bseq_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .suspend (suspend),
        .adv     (adv),
        .sel     (sel),
        .cmd_wr  (cmd_wr),
        .op      (op),
        .active  (active),
        .beat    (beat),
        .wr      (wr)
    );

    // Address capture enable.
    always_comb load = (op == OP_LOAD);

    // Start address storage.
    bseq_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_areg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ext_addr (ext_addr),
        .upper    (upper),
        .start_lo (start_lo)
    );

    // Beat ordering of the low bits.
    bseq_order #(.BEAT_W(BEAT_W)) u_order (
        .start_lo (start_lo),
        .beat     (beat),
        .ilv_mode (ilv_mode),
        .lo       (lo)
    );

    // Drive the pipeline outputs from the registered state.
    always_comb begin
        arr_addr  = {upper, lo};
        arr_valid = active;
        arr_wr    = wr;
    end

endmodule

// File: rtl/bseq_checker.sv
// Module: bseq_checker
// Temporal checks of the burst address sequencer at its ports; bound to
// every instance of the top module.
// Assumes: synchronous active-low reset.
module bseq_checker #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              suspend,
    input logic              adv,
    input logic              sel,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              cmd_wr,
    input logic              ilv_mode,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_valid,
    input logic              arr_wr
);

    // Selected load sets valid and takes address and control (R2).
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && !adv && sel) |=>
            (arr_valid && arr_addr == $past(ext_addr) && arr_wr == $past(cmd_wr)));

    // Upper address bits fixed across an advance (R3).
    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && adv && arr_valid) |=>
            (arr_valid && arr_addr[ADDR_W-1:BEAT_W] == $past(arr_addr[ADDR_W-1:BEAT_W])));

    // Linear order counts the low bits up with wrap (R4, R6).
    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && adv && arr_valid && !ilv_mode) |=>
            (arr_addr[BEAT_W-1:0] == BEAT_W'($past(arr_addr[BEAT_W-1:0]) + 1'b1)));

    // Deselected load ends the burst (R7).
    p_deselect_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && !adv && !sel) |=> !arr_valid);

    // Advance with no burst gives no access (R7).
    p_idle_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && adv && !arr_valid) |=> !arr_valid);

    // Suspend freezes the outputs (R8).
    p_suspend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> ($stable(arr_addr) && $stable(arr_valid) && $stable(arr_wr)));

    // Write flag kept through the burst (R9).
    p_wr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && adv && arr_valid) |=> (arr_wr == $past(arr_wr)));

endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bseq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .suspend   (suspend),
    .adv       (adv),
    .sel       (sel),
    .ext_addr  (ext_addr),
    .cmd_wr    (cmd_wr),
    .ilv_mode  (ilv_mode),
    .arr_addr  (arr_addr),
    .arr_valid (arr_valid),
    .arr_wr    (arr_wr)
);

// File: tb/burst_addr_seq_bench.sv
// Bench: burst_addr_seq_bench
// Scoreboard bench: the driver task applies one cycle of stimulus, works
// out the expected outputs from the requirements and queues them; the
// monitor compares them one cycle later, away from the active edge.
module burst_addr_seq_bench;

    localparam int ADDR_W = 17;

    typedef struct {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        int                due;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              suspend = 1'b0;
    logic              adv = 1'b1;
    logic              sel = 1'b0;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              cmd_wr = 1'b0;
    logic              ilv_mode = 1'b0;
    logic [ADDR_W-1:0] arr_addr;
    logic              arr_valid;
    logic              arr_wr;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Reference state kept by the bench.
    logic                m_valid = 1'b0;
    logic [ADDR_W-3:0]   m_up = '0;
    logic [1:0]          m_start = '0;
    logic [1:0]          m_beat = '0;
    logic                m_wr = 1'b0;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .suspend   (suspend),
        .adv       (adv),
        .sel       (sel),
        .ext_addr  (ext_addr),
        .cmd_wr    (cmd_wr),
        .ilv_mode  (ilv_mode),
        .arr_addr  (arr_addr),
        .arr_valid (arr_valid),
        .arr_wr    (arr_wr)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Cycle stamp for the scoreboard.
    always @(posedge clk) cyc <= cyc + 1;

    // Drive one cycle, update the reference and queue the expectation.
    task automatic step(input logic a, input logic s, input logic [ADDR_W-1:0] ad,
                        input logic w, input logic susp, input string tag);
        exp_t e;
        logic [1:0] lo;
        @(negedge clk);
        adv = a; sel = s; ext_addr = ad; cmd_wr = w; suspend = susp;
        if (!susp) begin
            if (!a) begin
                if (s) begin
                    m_valid = 1'b1; m_up = ad[ADDR_W-1:2]; m_start = ad[1:0];
                    m_beat = 2'd0; m_wr = w;
                end else begin
                    m_valid = 1'b0;
                end
            end else if (m_valid) begin
                m_beat = m_beat + 2'd1;
            end
        end
        lo = ilv_mode ? (m_start ^ m_beat) : (m_start + m_beat);
        e.valid = m_valid;
        e.addr  = {m_up, lo};
        e.wr    = m_wr;
        e.due   = cyc + 1;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare queued expectations when they fall due.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (arr_valid !== e.valid ||
                (e.valid && (arr_addr !== e.addr || arr_wr !== e.wr))) begin
                errors++;
                $display("FAIL %s: valid=%0b addr=%h wr=%0b, expected valid=%0b addr=%h wr=%0b",
                         e.tag, arr_valid, arr_addr, arr_wr, e.valid, e.addr, e.wr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (arr_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%0b during reset, expected 0", arr_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (arr_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%0b after reset, expected 0", arr_valid);
        end

        // Linear burst from low bits 2, external address scrambled on advances.
        ilv_mode = 1'b0;
        step(1'b0, 1'b1, 17'h1ABC6, 1'b0, 1'b0, "R2 load");
        step(1'b1, 1'b0, 17'h00000, 1'b1, 1'b0, "R3 R4 beat1");
        step(1'b1, 1'b1, 17'h1FFFF, 1'b1, 1'b0, "R3 R4 beat2");
        step(1'b1, 1'b0, 17'h05A5A, 1'b0, 1'b0, "R4 beat3");
        step(1'b1, 1'b1, 17'h00001, 1'b0, 1'b0, "R6 wrap");

        // Suspend carries a selected load that must not take effect.
        step(1'b0, 1'b1, 17'h05555, 1'b1, 1'b1, "R8 hold");
        step(1'b0, 1'b0, 17'h0AAAA, 1'b1, 1'b1, "R8 hold");
        step(1'b1, 1'b0, 17'h00000, 1'b0, 1'b0, "R4 after suspend");

        // Deselect ends the burst; advances stay idle.
        step(1'b0, 1'b0, 17'h03333, 1'b0, 1'b0, "R7 end");
        step(1'b1, 1'b1, 17'h03333, 1'b1, 1'b0, "R7 idle adv");
        step(1'b1, 1'b0, 17'h04444, 1'b0, 1'b0, "R7 idle adv");

        // Interleaved write burst from low bits 1.
        @(negedge clk);
        ilv_mode = 1'b1;
        step(1'b0, 1'b1, 17'h0F0F1, 1'b1, 1'b0, "R2 R9 load");
        step(1'b1, 1'b0, 17'h00000, 1'b0, 1'b0, "R5 R9 beat1");
        step(1'b1, 1'b1, 17'h12345, 1'b0, 1'b0, "R5 beat2");
        step(1'b1, 1'b0, 17'h1FFFF, 1'b0, 1'b0, "R5 R9 beat3");
        step(1'b1, 1'b0, 17'h00002, 1'b0, 1'b0, "R6 wrap");

        // Back-to-back load replaces the running burst.
        step(1'b0, 1'b1, 17'h12343, 1'b0, 1'b0, "R2 reload");
        step(1'b1, 1'b0, 17'h00000, 1'b1, 1'b0, "R5 R9 beat1");
        step(1'b1, 1'b0, 17'h00000, 1'b1, 1'b0, "R5 beat2");

        // Suspend during an interleaved burst.
        step(1'b1, 1'b1, 17'h1F000, 1'b1, 1'b1, "R8 hold");
        step(1'b1, 1'b0, 17'h00000, 1'b0, 1'b0, "R5 beat3");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule